// File: doc/BRIEF.md
# Banked Scratchpad Conflict Resolver

This block sits in front of a sixteen-bank on-chip scratchpad and turns one group access from sixteen threads into a short series of bank cycles. Each thread supplies a word address and a valid bit. All threads share one read/write flag. The low address bits pick a bank and the remaining bits pick a row inside that bank. Every bank can serve one 32-bit word per cycle.

Each cycle, each bank looks at the threads still waiting on it and serves the lowest-numbered one. Every other waiting thread that wants the very same word is served in that cycle too. This is how a read from one address by all threads finishes in a single cycle as a broadcast. Threads that want different words in the same bank are spread over later cycles. The access therefore takes as many cycles as the largest number of distinct words asked of any one bank. When several threads write the same word, the highest-numbered thread's data is stored.

Read results are gathered per thread. When the last word has been served, a one-cycle done pulse is raised together with the number of cycles the access used. The bank arrays are outside the block: it drives per-bank enables, rows and write data, and it takes per-bank read data back in the same cycle.

Top module: `smem_bank_resolver`

## Requirements
- R1: After reset, req_ready is 1, done is 0 and every bank_en bit is 0. No bank is enabled while no access is in progress.
- R2: A thread's bank is its address bits [3:0] (address mod 16). The row sent on bank_row for that bank is address bits [7:4].
- R3: If all valid threads use different banks, the access is served in one cycle. For every access, done is raised exactly done_degree cycles after the clock edge that accepted the request.
- R4: When every thread reads the same address, done_degree is 1 and every thread's lane_rdata holds that word.
- R5: done_degree equals the largest count, over all banks, of distinct addresses among the valid threads that map to that bank.
- R6: Within a bank, the waiting thread with the lowest index is served first, one distinct word per cycle. Threads that ask for the same word are served together in that cycle.
- R7: When several valid threads write the same word, the word stored is the data of the highest-numbered of them. A write access leaves lane_rdata unchanged.
- R8: Threads whose req_mask bit is 0 cause no bank access, do not add to done_degree, and keep their previous lane_rdata. A request with an all-zero mask raises done in the cycle after acceptance with done_degree 0.
- R9: While an access is in progress, req_ready is 0 and req_valid is ignored.
- R10: Every accepted request yields exactly one done pulse. lane_rdata is valid for all served read threads while done is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 for a write access, 0 for a read access |
| req_mask | input | 16 | Valid bit per thread |
| req_addr | input | 16x8 | Word address per thread |
| req_wdata | input | 16x32 | Write data per thread |
| bank_en | output | 16 | Access enable per bank |
| bank_we | output | 1 | Write enable shared by all enabled banks |
| bank_row | output | 16x4 | Row address per bank |
| bank_wdata | output | 16x32 | Write data per bank |
| bank_rdata | input | 16x32 | Read data per bank, valid in the same cycle as the enable |
| done | output | 1 | One-cycle pulse when an access has completed |
| done_degree | output | 5 | Cycles used by the completed access |
| lane_rdata | output | 16x32 | Gathered read data per thread |

## Verification
The bench targets the strided patterns: stride 1 gives one cycle, stride 2 gives two, stride 8 gives eight and stride 16 gives sixteen. A resolver that counted threads instead of distinct words, or that took the bank from the wrong address bits, would report a wrong degree or the wrong done timing. An all-thread broadcast read and an all-thread write to one word check that identical addresses are merged. A missing merge would report sixteen cycles, and a wrong write priority shows up when the word is read back. Further checks cover masked-off threads that point at a busy bank, an empty mask, a request that arrives while an access is in progress (an accepted one would produce an extra done pulse or corrupt memory), and the row served first in a bank with mixed words.

// File: rtl/smem_pkg.sv
package smem_pkg;
    localparam int DEF_LANES  = 16;
    localparam int DEF_BANKS  = 16;
    localparam int DEF_ADDR_W = 8;
    localparam int DEF_DATA_W = 32;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_kind_e;
endpackage

// File: rtl/smem_bank_arbiter.sv
module smem_bank_arbiter #(
    parameter int LANES     = 16,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int BANK_BITS = 4,
    parameter int BANK_ID   = 0
) (
    input  logic [LANES-1:0]                pending,
    input  logic [LANES-1:0][ADDR_W-1:0]    addr,
    input  logic [LANES-1:0][DATA_W-1:0]    wdata,
    output logic                            en,
    output logic [ADDR_W-BANK_BITS-1:0]     row,
    output logic [DATA_W-1:0]               wsel,
    output logic [LANES-1:0]                served
);
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic              found;
    logic [LANE_W-1:0] lead;
    logic [ADDR_W-1:0] lead_addr;

    // pick the lowest waiting thread that maps to this bank
    always_comb begin
        found = 1'b0;
        lead  = '0;
        for (int i = 0; i < LANES; i++) begin
            if (!found && pending[i] &&
                addr[i][BANK_BITS-1:0] == BANK_BITS'(BANK_ID)) begin
                found = 1'b1;
                lead  = LANE_W'(i);
            end
        end
    end

    assign lead_addr = addr[lead];

    // every waiting thread on the same word rides along; last writer wins
    always_comb begin
        served = '0;
        wsel   = '0;
        for (int i = 0; i < LANES; i++) begin
            if (found && pending[i] && addr[i] == lead_addr) begin
                served[i] = 1'b1;
                wsel      = wdata[i];
            end
        end
    end

    assign en  = found;
    assign row = lead_addr[ADDR_W-1:BANK_BITS];
endmodule

// File: rtl/smem_lane_return.sv
module smem_lane_return #(
    parameter int LANES     = 16,
    parameter int BANKS     = 16,
    parameter int DATA_W    = 32,
    parameter int BANK_BITS = 4
) (
    input  logic [BANKS-1:0][LANES-1:0]     served_by_bank,
    input  logic [BANKS-1:0][DATA_W-1:0]    bank_rdata,
    input  logic [LANES-1:0][BANK_BITS-1:0] lane_bank,
    output logic [LANES-1:0]                served,
    output logic [LANES-1:0][DATA_W-1:0]    lane_data
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign served[l]    = served_by_bank[lane_bank[l]][l];
        assign lane_data[l] = bank_rdata[lane_bank[l]];
    end
endmodule

// File: rtl/smem_bank_resolver.sv
module smem_bank_resolver
    import smem_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int BANKS  = DEF_BANKS,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    localparam int BANK_BITS = $clog2(BANKS),
    localparam int ROW_W     = ADDR_W - BANK_BITS,
    localparam int CNT_W     = $clog2(LANES + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_write,
    input  logic [LANES-1:0]              req_mask,
    input  logic [LANES-1:0][ADDR_W-1:0]  req_addr,
    input  logic [LANES-1:0][DATA_W-1:0]  req_wdata,
    output logic [BANKS-1:0]              bank_en,
    output logic                          bank_we,
    output logic [BANKS-1:0][ROW_W-1:0]   bank_row,
    output logic [BANKS-1:0][DATA_W-1:0]  bank_wdata,
    input  logic [BANKS-1:0][DATA_W-1:0]  bank_rdata,
    output logic                          done,
    output logic [CNT_W-1:0]              done_degree,
    output logic [LANES-1:0][DATA_W-1:0]  lane_rdata
);
    typedef struct packed {
        logic                         busy;
        acc_kind_e                    kind;
        logic [LANES-1:0]             pending;
        logic [LANES-1:0][ADDR_W-1:0] addr;
        logic [LANES-1:0][DATA_W-1:0] wdata;
        logic [LANES-1:0][DATA_W-1:0] rdata;
        logic [CNT_W-1:0]             count;
        logic                         done;
        logic [CNT_W-1:0]             degree;
    } state_t;

    state_t q, d;

    logic [BANKS-1:0]                 arb_en;
    logic [BANKS-1:0][ROW_W-1:0]      arb_row;
    logic [BANKS-1:0][DATA_W-1:0]     arb_wd;
    logic [BANKS-1:0][LANES-1:0]      arb_served;
    logic [LANES-1:0][BANK_BITS-1:0]  lane_bank;
    logic [LANES-1:0]                 lane_served;
    logic [LANES-1:0][DATA_W-1:0]     lane_hit;

    // one arbiter per bank, each bound to its own bank index
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        smem_bank_arbiter #(
            .LANES    (LANES),
            .ADDR_W   (ADDR_W),
            .DATA_W   (DATA_W),
            .BANK_BITS(BANK_BITS),
            .BANK_ID  (b)
        ) i_arb (
            .pending(q.pending),
            .addr   (q.addr),
            .wdata  (q.wdata),
            .en     (arb_en[b]),
            .row    (arb_row[b]),
            .wsel   (arb_wd[b]),
            .served (arb_served[b])
        );
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane_bank
        assign lane_bank[l] = q.addr[l][BANK_BITS-1:0];
    end

    smem_lane_return #(
        .LANES    (LANES),
        .BANKS    (BANKS),
        .DATA_W   (DATA_W),
        .BANK_BITS(BANK_BITS)
    ) i_ret (
        .served_by_bank(arb_served),
        .bank_rdata    (bank_rdata),
        .lane_bank     (lane_bank),
        .served        (lane_served),
        .lane_data     (lane_hit)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (req_valid) begin
                d.kind    = req_write ? ACC_WRITE : ACC_READ;
                d.pending = req_mask;
                d.addr    = req_addr;
                d.wdata   = req_wdata;
                d.count   = '0;
                if (req_mask == '0) begin
                    d.done   = 1'b1;
                    d.degree = '0;
                end else begin
                    d.busy = 1'b1;
                end
            end
        end else begin
            d.pending = q.pending & ~lane_served;
            for (int l = 0; l < LANES; l++) begin
                if (lane_served[l] && q.kind == ACC_READ) begin
                    d.rdata[l] = lane_hit[l];
                end
            end
            d.count = q.count + 1'b1;
            if (d.pending == '0) begin
                d.busy   = 1'b0;
                d.done   = 1'b1;
                d.degree = q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready   = !q.busy;
    assign bank_en     = q.busy ? arb_en : '0;
    assign bank_we     = (q.kind == ACC_WRITE);
    assign bank_row    = arb_row;
    assign bank_wdata  = arb_wd;
    assign done        = q.done;
    assign done_degree = q.degree;
    assign lane_rdata  = q.rdata;

    // no arbiter may request a bank while nothing is in flight
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> arb_en == '0);

    // every serving cycle retires at least one thread
    assert_progress_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> lane_served != '0);

    assert_degree_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> done_degree <= CNT_W'(LANES));

    // completion is reported only once the block is free again
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    assert_kind_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy && $past(q.busy) |-> $stable(bank_we));

    // captured addresses stay put while serving, whatever req_valid does
    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |=> $stable(q.addr));
endmodule

// File: tb/test_smem_bank_resolver.sv
module test_smem_bank_resolver;
    localparam int LANES  = 16;
    localparam int BANKS  = 16;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int ROWS   = 1 << (ADDR_W - 4);
    localparam int WORDS  = 1 << ADDR_W;
    localparam int VW     = LANES * DATA_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_write = 1'b0;
    logic [LANES-1:0] req_mask = '0;
    logic [LANES-1:0][ADDR_W-1:0] req_addr = '0;
    logic [LANES-1:0][DATA_W-1:0] req_wdata = '0;
    logic [BANKS-1:0] bank_en;
    logic bank_we;
    logic [BANKS-1:0][3:0] bank_row;
    logic [BANKS-1:0][DATA_W-1:0] bank_wdata;
    logic [BANKS-1:0][DATA_W-1:0] bank_rdata;
    logic done;
    logic [4:0] done_degree;
    logic [LANES-1:0][DATA_W-1:0] lane_rdata;

    smem_bank_resolver i_smem_bank_resolver (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_mask(req_mask), .req_addr(req_addr),
        .req_wdata(req_wdata), .bank_en(bank_en), .bank_we(bank_we),
        .bank_row(bank_row), .bank_wdata(bank_wdata), .bank_rdata(bank_rdata),
        .done(done), .done_degree(done_degree), .lane_rdata(lane_rdata)
    );

    always #2 clk = ~clk;

    function automatic logic [DATA_W-1:0] seed_word(int a);
        return 32'hC0DE0000 ^ (a * 32'h00010003);
    endfunction

    // behavioural banks
    logic [DATA_W-1:0] mem [BANKS][ROWS];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < BANKS; b++)
                for (int r = 0; r < ROWS; r++) mem[b][r] <= seed_word(r * 16 + b);
        end else begin
            for (int b = 0; b < BANKS; b++)
                if (bank_en[b] && bank_we) mem[b][bank_row[b]] <= bank_wdata[b];
        end
    end
    always_comb begin
        for (int b = 0; b < BANKS; b++) bank_rdata[b] = mem[b][bank_row[b]];
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    logic [DATA_W-1:0] shadow [WORDS];
    logic [LANES-1:0][DATA_W-1:0] exp_lane = '0;

    int q_deg[$];
    int q_acc[$];
    logic [VW-1:0] q_dat[$];
    string q_tag[$];

    task automatic chk(input bit ok, input string what, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q_deg.size() == 0) begin
                chk(1'b0, "R10 done pulse with no accepted request", 1, 0);
            end else begin
                int dg; int ac; logic [VW-1:0] dt; string tg;
                dg = q_deg.pop_front(); ac = q_acc.pop_front();
                dt = q_dat.pop_front(); tg = q_tag.pop_front();
                chk(done_degree == 5'(dg), {tg, " R5 done_degree"}, VW'(done_degree), VW'(dg));
                chk(cyc - ac == dg, {tg, " R3 done latency"}, VW'(cyc - ac), VW'(dg));
                chk(lane_rdata == dt, {tg, " R10 lane_rdata"}, lane_rdata, dt);
            end
        end
    end

    // driver: builds the expectation, then presents the request
    task automatic issue(input logic wr, input logic [LANES-1:0] m,
                         input logic [LANES-1:0][ADDR_W-1:0] a,
                         input logic [LANES-1:0][DATA_W-1:0] wd, input string tag);
        int worst;
        while (!req_ready) @(negedge clk);
        worst = 0;
        for (int b = 0; b < BANKS; b++) begin
            int cnt = 0;
            for (int i = 0; i < LANES; i++) begin
                bit seen = 0;
                if (!m[i] || int'(a[i][3:0]) != b) continue;
                for (int j = 0; j < i; j++) if (m[j] && a[j] == a[i]) seen = 1;
                if (!seen) cnt++;
            end
            if (cnt > worst) worst = cnt;
        end
        for (int i = 0; i < LANES; i++) begin
            if (m[i]) begin
                if (wr) shadow[a[i]] = wd[i];
                else    exp_lane[i] = shadow[a[i]];
            end
        end
        q_deg.push_back(worst);
        q_acc.push_back(cyc + 1);
        q_dat.push_back(exp_lane);
        q_tag.push_back(tag);
        req_write = wr; req_mask = m; req_addr = a; req_wdata = wd;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [LANES-1:0][ADDR_W-1:0] a;
        logic [LANES-1:0][DATA_W-1:0] wd;
        for (int w = 0; w < WORDS; w++) shadow[w] = seed_word(w);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done && bank_en == '0, "R1 reset state",
            VW'({req_ready, done, bank_en}), VW'({1'b1, 1'b0, 16'h0}));

        // R2: one thread at 0x37 -> bank 7, row 3
        a = '0; a[5] = 8'h37; wd = '0;
        issue(1'b0, 16'h0020, a, wd, "R2");
        chk(bank_en == 16'h0080 && bank_row[7] == 4'h3, "R2 bank and row mapping",
            VW'({bank_en, bank_row[7]}), VW'({16'h0080, 4'h3}));

        // R3: stride 1, every bank once
        for (int i = 0; i < LANES; i++) a[i] = 8'(i * 17);
        issue(1'b0, '1, a, wd, "R3");

        // R4: broadcast read
        for (int i = 0; i < LANES; i++) a[i] = 8'h4B;
        issue(1'b0, '1, a, wd, "R4");

        // R5: strides 2, 8, 16
        for (int i = 0; i < LANES; i++) a[i] = 8'(i * 2);
        issue(1'b0, '1, a, wd, "R5 stride2");
        for (int i = 0; i < LANES; i++) a[i] = 8'(i * 8);
        issue(1'b0, '1, a, wd, "R5 stride8");
        for (int i = 0; i < LANES; i++) a[i] = 8'(i * 16);
        issue(1'b0, '1, a, wd, "R5 stride16");

        // R6: bank 0 holds rows 5 and 2; lanes 1 and 3 share row 2
        a = '0; a[0] = 8'h50; a[1] = 8'h20; a[3] = 8'h20;
        issue(1'b0, 16'h000B, a, wd, "R6");
        chk(bank_en[0] && bank_row[0] == 4'h5, "R6 lowest thread served first",
            VW'(bank_row[0]), VW'(4'h5));
        @(negedge clk);
        chk(bank_en[0] && bank_row[0] == 4'h2, "R6 merged second word",
            VW'(bank_row[0]), VW'(4'h2));

        // R7: all threads write one word, then read it back
        for (int i = 0; i < LANES; i++) begin a[i] = 8'h33; wd[i] = 32'hBEEF0000 + 32'(i); end
        issue(1'b1, '1, a, wd, "R7 write");
        for (int i = 0; i < LANES; i++) a[i] = 8'h33;
        issue(1'b0, 16'h0001, a, wd, "R7 readback");
        while (!done) @(negedge clk);
        chk(lane_rdata[0] == 32'hBEEF000F, "R7 highest writer wins",
            VW'(lane_rdata[0]), VW'(32'hBEEF000F));

        // R8: masked threads crowd bank 0 but only lane 2 is valid
        for (int i = 0; i < LANES; i++) a[i] = 8'(i * 16);
        issue(1'b0, 16'h0004, a, wd, "R8 masked");
        issue(1'b0, 16'h0000, a, wd, "R8 empty");

        // R9: stride 4 takes four cycles; poke req_valid meanwhile
        for (int i = 0; i < LANES; i++) begin a[i] = 8'(i * 4); wd[i] = 32'hDEAD0000; end
        issue(1'b0, '1, a, wd, "R9");
        chk(!req_ready, "R9 ready low while busy", VW'(req_ready), VW'(0));
        req_write = 1'b1; req_mask = '1; req_valid = 1'b1;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < LANES; i++) a[i] = 8'(i * 4);
        issue(1'b0, '1, a, wd, "R9 readback");

        // mixed traffic
        for (int t = 0; t < 24; t++) begin
            logic [LANES-1:0] m;
            m = 16'($urandom);
            for (int i = 0; i < LANES; i++) begin
                a[i] = 8'($urandom_range(0, 63));
                wd[i] = $urandom;
            end
            issue(1'($urandom), m, a, wd, "R5 mixed");
        end

        while (!req_ready || q_deg.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(q_deg.size() == 0, "R10 every request completed", VW'(q_deg.size()), VW'(0));
        finish_run();
    end
endmodule